// File: doc/BRIEF.md
# Configuration TLP Request Engine

This block turns one configuration-space access into a four-word request packet: three header words followed by one data word. It sends that packet on a 32-bit streaming transmit port, then waits for the matching completion on a 32-bit streaming receive port. The caller supplies the target bus, device, function, register offset, access size and write data. It also supplies the root bus number, used to build the requester ID, and the secondary bus number, which decides whether a Type 0 or a Type 1 request goes out. The engine derives the byte enables, the format/type code and the tag on its own.

Only one request is in flight at a time. A request is taken on the request port when the engine is idle. The engine then reports the result with a single-cycle `done` pulse, together with the read data and two error flags: a failed completion status, and no completion arriving in time. A failed access returns all ones as its data.

Both packet ports follow valid/ready rules. A word moves only in a cycle where valid and ready are both high. While the transmitter holds `tx_valid` and `tx_ready` is low, the transmitter keeps `tx_data`, `tx_sop` and `tx_eop` unchanged. The receive side raises `rx_ready` only while a completion is expected, so the completion source is back-pressured at all other times. The request port is plain valid/ready: `req_ready` is high exactly when the engine is idle.

Top module: `cfg_tlp_engine`

## Requirements
- R1: Header word 0 is `{code, 24'h000001}`, where code is 8'h04 for a Type 0 read, 8'h44 for a Type 0 write, 8'h05 for a Type 1 read and 8'h45 for a Type 1 write.
- R2: Type 1 is chosen when `req_bus` is strictly greater than `sec_bus`; otherwise Type 0 is chosen.
- R3: Header word 1 is `{root_bus, 8'h00, tag, byte_enables}`, with tag 8'h1D for reads and 8'h10 for writes.
- R4: `req_size` is encoded 0 for byte, 1 for halfword, and 2 or 3 for word. Byte enables are 8'h01 shifted left by `offset[1:0]` for a byte, 8'h03 shifted left by `offset[1:0]` for a halfword, and 8'h0F for a word.
- R5: Header word 2 is `{bus, dev[4:0], fn[2:0], 4'h0, offset[11:2], 2'b00}`, so the offset's two low bits are cleared.
- R6: The four words leave in order: header 0, header 1, header 2, data. `tx_sop` is set only on header 0 and `tx_eop` only on the data word. A read sends 0 as its data word. A write sends its byte or halfword shifted up by `8*offset[1:0]` bits, and a word write sends `req_wdata` unchanged. A word held while `tx_ready` is low keeps its value.
- R7: In the completion, status is bits 15:13 of the second word. A nonzero status ends the access with `done_cpl_fail` high and `done_rdata` all ones, for reads and writes alike.
- R8: A successful read returns the completion's fourth word only when the byte count in bits 11:0 of the second word equals 4 and at least four words arrived. Otherwise it returns 0. A successful write returns 0.
- R9: For a byte or halfword read, the selected lanes (starting at byte `offset[1:0]`) are shifted down to bit 0 and the upper bits are zero.
- R10: If no start-of-packet word is accepted within TIMEOUT_POLLS (default 20000) cycles after the last transmit word, the access ends with `done_timeout` high and `done_rdata` all ones. Received words without `rx_sop` are discarded while the engine waits.
- R11: `req_ready` is high only when idle, and a request is captured only then. Requests offered while busy start nothing. `done` lasts exactly one cycle.
- R12: After reset, `req_ready` is 1 and `tx_valid`, `rx_ready` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_offset | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code (R4) |
| req_wdata | input | 32 | Write value, right-aligned |
| root_bus | input | 8 | Root bus number for the requester ID |
| sec_bus | input | 8 | Secondary bus number for the Type 0/1 choice |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Transmit sink accepts |
| tx_data | output | 32 | Transmit word |
| tx_sop | output | 1 | First word of packet |
| tx_eop | output | 1 | Last word of packet |
| rx_valid | input | 1 | Completion word valid |
| rx_ready | output | 1 | Engine accepts completion words |
| rx_data | input | 32 | Completion word |
| rx_sop | input | 1 | First word of completion |
| rx_eop | input | 1 | Last word of completion |
| done | output | 1 | One-cycle result strobe |
| done_rdata | output | 32 | Result data, valid with done |
| done_cpl_fail | output | 1 | Completion status was nonzero |
| done_timeout | output | 1 | No completion start seen in time |

## Verification
The vectors vary the target bus against the secondary bus on both sides of equality, so that Type 0 and Type 1 codes differ. They mix reads and writes so that tag, code and data-word placement separate, and they sweep byte, halfword and word sizes at every lane offset, which exposes shift and enable errors. Completions vary in status, byte count and length, so the all-ones, zero and data paths each show up. Directed cases cover a stray non-start word, a late start that must not time out, a real timeout, and requests offered while busy.

// File: rtl/cfgtlp_pkg.sv
package cfgtlp_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD3 = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic       wr;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [11:0] off;
    acc_size_e  size;
    logic [31:0] wdata;
    logic [7:0] root;
    logic [7:0] sec;
  } cfg_req_t;

  localparam logic [7:0] FT_RD_T0 = 8'h04;
  localparam logic [7:0] FT_WR_T0 = 8'h44;
  localparam logic [7:0] FT_RD_T1 = 8'h05;
  localparam logic [7:0] FT_WR_T1 = 8'h45;
  localparam logic [7:0] TAG_RD   = 8'h1D;
  localparam logic [7:0] TAG_WR   = 8'h10;
  localparam logic [23:0] LEN_ONE = 24'h000001;

  function automatic logic [7:0] lane_enables(input acc_size_e s, input logic [1:0] lo);
    case (s)
      ACC_BYTE: lane_enables = 8'h01 << lo;
      ACC_HALF: lane_enables = 8'h03 << lo;
      default:  lane_enables = 8'h0F;
    endcase
  endfunction

  function automatic logic [31:0] lanes_down(input logic [31:0] d, input acc_size_e s,
                                             input logic [1:0] lo);
    logic [31:0] sh;
    sh = d >> {lo, 3'b000};
    case (s)
      ACC_BYTE: lanes_down = {24'h0, sh[7:0]};
      ACC_HALF: lanes_down = {16'h0, sh[15:0]};
      default:  lanes_down = d;
    endcase
  endfunction

  function automatic logic [31:0] lanes_up(input logic [31:0] d, input acc_size_e s,
                                           input logic [1:0] lo);
    case (s)
      ACC_BYTE: lanes_up = {24'h0, d[7:0]} << {lo, 3'b000};
      ACC_HALF: lanes_up = {16'h0, d[15:0]} << {lo, 3'b000};
      default:  lanes_up = d;
    endcase
  endfunction

endpackage

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfgtlp_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PKT_WORDS = 4
) (
  input  cfg_req_t                       req,
  output logic [PKT_WORDS-1:0][WORD_W-1:0] words
);
  logic       type1;
  logic [7:0] code;
  logic [7:0] tag;
  logic [7:0] be;

  always_comb begin
    type1 = (req.bus > req.sec);
    if (req.wr) code = type1 ? FT_WR_T1 : FT_WR_T0;
    else        code = type1 ? FT_RD_T1 : FT_RD_T0;
    tag = req.wr ? TAG_WR : TAG_RD;
    be  = lane_enables(req.size, req.off[1:0]);
  end

  always_comb begin
    words    = '0;
    words[0] = {code, LEN_ONE};
    words[1] = {req.root, 8'h00, tag, be};
    words[2] = {req.bus, req.dev, req.fn, 4'h0, req.off[11:2], 2'b00};
    words[PKT_WORDS-1] = req.wr ? lanes_up(req.wdata, req.size, req.off[1:0]) : '0;
  end
endmodule

// File: rtl/cfg_tx_serializer.sv
module cfg_tx_serializer #(
  parameter int WORD_W    = 32,
  parameter int PKT_WORDS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go,
  input  logic [PKT_WORDS-1:0][WORD_W-1:0] words,
  output logic                           tx_valid,
  input  logic                           tx_ready,
  output logic [WORD_W-1:0]              tx_data,
  output logic                           tx_sop,
  output logic                           tx_eop,
  output logic                           last_beat
);
  localparam int IDX_W = $clog2(PKT_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             beat;

  assign tx_valid  = go;
  assign tx_data   = words[idx_q];
  assign tx_sop    = go && (idx_q == '0);
  assign tx_eop    = go && (idx_q == LAST_IDX);
  assign beat      = go && tx_ready;
  assign last_beat = beat && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)         idx_q <= '0;
    else if (last_beat) idx_q <= '0;
    else if (beat)      idx_q <= idx_q + 1'b1;
  end

  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  a_r6_marks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));
endmodule

// File: rtl/cfg_cpl_collector.sv
module cfg_cpl_collector #(
  parameter int WORD_W        = 32,
  parameter int TIMEOUT_POLLS = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  output logic              fin,
  output logic              fin_timeout,
  output logic [2:0]        fin_status,
  output logic [11:0]       fin_bytecnt,
  output logic              fin_has_data,
  output logic [WORD_W-1:0] fin_data
);
  localparam int PW = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(TIMEOUT_POLLS - 1);

  typedef enum logic [1:0] {C_OFF, C_HUNT, C_GATHER} cstate_e;

  cstate_e            st_q;
  logic [PW-1:0]      poll_q;
  logic [2:0]         nw_q;
  logic [WORD_W-1:0]  w1_q;
  logic [WORD_W-1:0]  w3_q;
  logic               take;

  assign rx_ready = (st_q != C_OFF);
  assign take     = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= C_OFF;
      poll_q      <= '0;
      nw_q        <= '0;
      w1_q        <= '0;
      w3_q        <= '0;
      fin         <= 1'b0;
      fin_timeout <= 1'b0;
    end else begin
      fin         <= 1'b0;
      fin_timeout <= 1'b0;
      case (st_q)
        C_OFF: begin
          if (arm) begin
            st_q   <= C_HUNT;
            poll_q <= '0;
            nw_q   <= '0;
            w1_q   <= '0;
            w3_q   <= '0;
          end
        end
        C_HUNT: begin
          if (take && rx_sop) begin
            nw_q <= 3'd1;
            if (rx_eop) begin
              st_q <= C_OFF;
              fin  <= 1'b1;
            end else begin
              st_q <= C_GATHER;
            end
          end else if (poll_q == POLL_LAST) begin
            st_q        <= C_OFF;
            fin         <= 1'b1;
            fin_timeout <= 1'b1;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        C_GATHER: begin
          if (take) begin
            if (nw_q == 3'd1) w1_q <= rx_data;
            if (nw_q == 3'd3) w3_q <= rx_data;
            if (nw_q != 3'd4) nw_q <= nw_q + 1'b1;
            if (rx_eop) begin
              st_q <= C_OFF;
              fin  <= 1'b1;
            end
          end
        end
        default: st_q <= C_OFF;
      endcase
    end
  end

  assign fin_status   = w1_q[15:13];
  assign fin_bytecnt  = w1_q[11:0];
  assign fin_has_data = (nw_q == 3'd4);
  assign fin_data     = w3_q;

  a_r10_timeout_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    fin && fin_timeout |-> $past(st_q) == C_HUNT && $past(poll_q) == POLL_LAST);

  a_r10_off_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !rx_ready);
endmodule

// File: rtl/cfg_tlp_engine.sv
module cfg_tlp_engine
  import cfgtlp_pkg::*;
#(
  parameter int TIMEOUT_POLLS = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_fn,
  input  logic [11:0] req_offset,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic [7:0]  root_bus,
  input  logic [7:0]  sec_bus,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_data,
  input  logic        rx_sop,
  input  logic        rx_eop,
  output logic        done,
  output logic [31:0] done_rdata,
  output logic        done_cpl_fail,
  output logic        done_timeout
);
  localparam int WORD_W    = 32;
  localparam int PKT_WORDS = 4;

  typedef enum logic [1:0] {E_IDLE, E_SEND, E_WAIT} estate_e;

  estate_e   st_q;
  cfg_req_t  req_q;
  logic [PKT_WORDS-1:0][WORD_W-1:0] hdr_words;
  logic      last_beat;
  logic      fin, fin_timeout, fin_has_data;
  logic [2:0]  fin_status;
  logic [11:0] fin_bytecnt;
  logic [31:0] fin_data;
  logic [31:0] result;
  logic        fail_now;

  assign req_ready = (st_q == E_IDLE);

  cfg_hdr_build #(.WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS)) u_hdr (
    .req   (req_q),
    .words (hdr_words)
  );

  cfg_tx_serializer #(.WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (st_q == E_SEND),
    .words     (hdr_words),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .last_beat (last_beat)
  );

  cfg_cpl_collector #(.WORD_W(WORD_W), .TIMEOUT_POLLS(TIMEOUT_POLLS)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (last_beat),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_data      (rx_data),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .fin          (fin),
    .fin_timeout  (fin_timeout),
    .fin_status   (fin_status),
    .fin_bytecnt  (fin_bytecnt),
    .fin_has_data (fin_has_data),
    .fin_data     (fin_data)
  );

  always_comb begin
    fail_now = !fin_timeout && (fin_status != 3'd0);
    if (fin_timeout || fail_now)
      result = '1;
    else if (req_q.wr)
      result = '0;
    else if (fin_bytecnt == 12'd4 && fin_has_data)
      result = lanes_down(fin_data, req_q.size, req_q.off[1:0]);
    else
      result = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= E_IDLE;
      req_q         <= '0;
      done          <= 1'b0;
      done_rdata    <= '0;
      done_cpl_fail <= 1'b0;
      done_timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        E_IDLE: begin
          if (req_valid) begin
            st_q  <= E_SEND;
            req_q <= '{wr: req_write, bus: req_bus, dev: req_dev, fn: req_fn,
                       off: req_offset, size: acc_size_e'(req_size), wdata: req_wdata,
                       root: root_bus, sec: sec_bus};
          end
        end
        E_SEND: if (last_beat) st_q <= E_WAIT;
        E_WAIT: begin
          if (fin) begin
            st_q          <= E_IDLE;
            done          <= 1'b1;
            done_rdata    <= result;
            done_cpl_fail <= fail_now;
            done_timeout  <= fin_timeout;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid && !rx_ready);

  a_r7_fail_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_cpl_fail |-> done_rdata == 32'hFFFF_FFFF && !done_timeout);

  a_r10_timeout_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_timeout |-> done_rdata == 32'hFFFF_FFFF);

  a_r6_send_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid |=> tx_valid && tx_sop);
endmodule

// File: tb/cfg_tlp_engine_bench.sv
module cfg_tlp_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_bus = 0, root_bus = 0, sec_bus = 0;
  logic [4:0]  req_dev = 0;
  logic [2:0]  req_fn = 0;
  logic [11:0] req_offset = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        tx_ready = 0;
  logic        rx_valid = 0, rx_sop = 0, rx_eop = 0;
  logic [31:0] rx_data = 0;
  logic        req_ready, tx_valid, tx_sop, tx_eop, rx_ready;
  logic [31:0] tx_data, done_rdata;
  logic        done, done_cpl_fail, done_timeout;

  cfg_tlp_engine u_cfg_tlp_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .root_bus(root_bus), .sec_bus(sec_bus), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .done(done), .done_rdata(done_rdata), .done_cpl_fail(done_cpl_fail),
    .done_timeout(done_timeout)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
    logic [1:0]  sz;
    logic [31:0] wdata;
    logic [7:0]  root;
    logic [7:0]  sec;
    logic [2:0]  st;
    logic [11:0] bc;
    logic [2:0]  nw;
    logic [31:0] cdata;
    logic [31:0] exp_rdata;
    logic        exp_fail;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1, 5'd0,  3'd0, 12'h000, 2'd2, 32'h0,        8'd0, 8'd1, 3'd0, 12'd4, 3'd4, 32'h12345678, 32'h12345678, 1'b0},
    '{1'b0, 8'd3, 5'd5,  3'd2, 12'h00E, 2'd1, 32'h0,        8'd0, 8'd1, 3'd0, 12'd4, 3'd4, 32'hAABBCCDD, 32'h0000AABB, 1'b0},
    '{1'b0, 8'd2, 5'd31, 3'd7, 12'h003, 2'd0, 32'h0,        8'd1, 8'd2, 3'd0, 12'd4, 3'd4, 32'hAABBCCDD, 32'h000000AA, 1'b0},
    '{1'b0, 8'd9, 5'd1,  3'd1, 12'hFF5, 2'd0, 32'h0,        8'd2, 8'd3, 3'd0, 12'd4, 3'd4, 32'hAABBCCDD, 32'h000000CC, 1'b0},
    '{1'b1, 8'd4, 5'd3,  3'd0, 12'h010, 2'd2, 32'hDEADBEEF, 8'd0, 8'd1, 3'd0, 12'd0, 3'd3, 32'h0,        32'h0,        1'b0},
    '{1'b1, 8'd1, 5'd0,  3'd0, 12'h03E, 2'd0, 32'h1234565A, 8'd0, 8'd1, 3'd0, 12'd0, 3'd3, 32'h0,        32'h0,        1'b0},
    '{1'b0, 8'd2, 5'd0,  3'd0, 12'h000, 2'd2, 32'h0,        8'd0, 8'd1, 3'd1, 12'd4, 3'd4, 32'h55555555, 32'hFFFFFFFF, 1'b1},
    '{1'b0, 8'd2, 5'd0,  3'd0, 12'h004, 2'd2, 32'h0,        8'd0, 8'd1, 3'd0, 12'd8, 3'd4, 32'h55555555, 32'h0,        1'b0},
    '{1'b0, 8'd2, 5'd0,  3'd0, 12'h008, 2'd2, 32'h0,        8'd0, 8'd1, 3'd0, 12'd4, 3'd3, 32'h55555555, 32'h0,        1'b0},
    '{1'b1, 8'd5, 5'd2,  3'd3, 12'h100, 2'd2, 32'hCAFEF00D, 8'd4, 8'd5, 3'd4, 12'd0, 3'd3, 32'h0,        32'hFFFFFFFF, 1'b1},
    '{1'b1, 8'd0, 5'd0,  3'd0, 12'h002, 2'd1, 32'hFFFF1234, 8'd0, 8'd0, 3'd0, 12'd0, 3'd3, 32'h0,        32'h0,        1'b0},
    '{1'b0, 8'd6, 5'd0,  3'd0, 12'h041, 2'd1, 32'h0,        8'd0, 8'd7, 3'd0, 12'd4, 3'd4, 32'h11223344, 32'h00002233, 1'b0},
    '{1'b0, 8'd8, 5'd4,  3'd5, 12'h0FC, 2'd3, 32'h0,        8'd3, 8'd7, 3'd0, 12'd4, 3'd4, 32'h0BADF00D, 32'h0BADF00D, 1'b0}
  };

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  logic        seen = 0;
  logic [31:0] got_rdata;
  logic        got_fail, got_tmo;

  always @(negedge clk) begin
    if (done) begin
      seen      = 1'b1;
      got_rdata = done_rdata;
      got_fail  = done_cpl_fail;
      got_tmo   = done_timeout;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  // expected packet words derived from R1..R6
  function automatic logic [31:0] exp_word(input vec_t v, input int k);
    logic       t1;
    logic [7:0] code, tag, be;
    logic [1:0] lo;
    logic [31:0] dw;
    lo = v.off[1:0];
    t1 = v.bus > v.sec;
    code = v.wr ? (t1 ? 8'h45 : 8'h44) : (t1 ? 8'h05 : 8'h04);
    tag  = v.wr ? 8'h10 : 8'h1D;
    case (v.sz)
      2'd0: be = 8'h01 << lo;
      2'd1: be = 8'h03 << lo;
      default: be = 8'h0F;
    endcase
    case (v.sz)
      2'd0: dw = {24'h0, v.wdata[7:0]} << (8 * lo);
      2'd1: dw = {16'h0, v.wdata[15:0]} << (8 * lo);
      default: dw = v.wdata;
    endcase
    case (k)
      0: exp_word = {code, 24'h000001};
      1: exp_word = {v.root, 8'h00, tag, be};
      2: exp_word = {v.bus, v.dev, v.fn, 4'h0, v.off[11:2], 2'b00};
      default: exp_word = v.wr ? dw : 32'h0;
    endcase
  endfunction

  task automatic issue(input vec_t v, input int stall_seed);
    logic [31:0] w [4];
    logic [3:0]  sops, eops;
    int n;
    int guard;
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_bus = v.bus; req_dev = v.dev; req_fn = v.fn;
    req_offset = v.off; req_size = v.sz; req_wdata = v.wdata; root_bus = v.root;
    sec_bus = v.sec;
    @(negedge clk);
    req_valid = 0;
    n = 0; guard = 0; sops = 0; eops = 0;
    while (n < 4 && guard < 200) begin
      tx_ready = ((guard + stall_seed) % 3) != 0;
      #1;
      if (tx_valid && tx_ready) begin
        w[n] = tx_data; sops[n] = tx_sop; eops[n] = tx_eop;
        n++;
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 0;
    check("R1 header word 0 code/length", w[0], exp_word(v, 0));
    check("R2 R3 R4 header word 1", w[1], exp_word(v, 1));
    check("R5 header word 2", w[2], exp_word(v, 2));
    check("R6 data word", w[3], exp_word(v, 3));
    check("R6 sop/eop marks", {28'h0, sops, eops}, {28'h0, 4'b0001, 4'b1000});
  endtask

  task automatic rx_word(input logic [31:0] d, input logic s, input logic e);
    rx_valid = 1; rx_data = d; rx_sop = s; rx_eop = e;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
  endtask

  task automatic send_cpl(input vec_t v);
    logic [31:0] cw [4];
    int nw;
    cw[0] = 32'h4A000001;
    cw[1] = {16'h0100, v.st, 1'b0, v.bc};
    cw[2] = 32'h00001D00;
    cw[3] = v.cdata;
    nw = int'(v.nw);
    for (int k = 0; k < nw; k++) rx_word(cw[k], k == 0, k == nw - 1);
  endtask

  task automatic wait_done(input int limit);
    int g;
    g = 0;
    while (!seen && g < limit) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 req_ready after reset", {31'h0, req_ready}, 32'h1);
    check("R12 tx_valid/rx_ready/done after reset", {29'h0, tx_valid, rx_ready, done}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      seen = 0;
      issue(VECS[i], i);
      send_cpl(VECS[i]);
      wait_done(50);
      check("R11 done seen", {31'h0, seen}, 32'h1);
      check("R7 R8 R9 result data", got_rdata, VECS[i].exp_rdata);
      check("R7 fail flag", {31'h0, got_fail}, {31'h0, VECS[i].exp_fail});
      check("R10 no timeout", {31'h0, got_tmo}, 32'h0);
    end

    // R10: stray non-start word is discarded, then a late start is accepted
    seen = 0;
    issue(VECS[0], 0);
    rx_word(32'h99999999, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    send_cpl(VECS[0]);
    wait_done(50);
    check("R10 stray word dropped, result", got_rdata, 32'h12345678);
    check("R10 late start no timeout", {31'h0, got_tmo}, 32'h0);

    // R11: request offered while busy starts nothing
    seen = 0;
    issue(VECS[4], 1);
    req_valid = 1; req_bus = 8'd77;
    repeat (5) @(negedge clk);
    check("R11 not ready while busy", {31'h0, req_ready}, 32'h0);
    req_valid = 0;
    send_cpl(VECS[4]);
    wait_done(50);
    check("R11 done after busy offer", {31'h0, seen}, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 no packet from busy offer", {31'h0, tx_valid}, 32'h0);
    check("R11 idle again", {31'h0, req_ready}, 32'h1);

    // R11: done lasts one cycle
    seen = 0;
    issue(VECS[0], 2);
    send_cpl(VECS[0]);
    wait_done(50);
    @(negedge clk);
    check("R11 done single cycle", {31'h0, done}, 32'h0);

    // R10: no completion at all
    seen = 0;
    issue(VECS[1], 0);
    wait_done(19990);
    check("R10 no early timeout", {31'h0, seen}, 32'h0);
    wait_done(100);
    check("R10 timeout reported", {31'h0, got_tmo}, 32'h1);
    check("R10 timeout data all ones", got_rdata, 32'hFFFFFFFF);
    check("R10 timeout not cpl fail", {31'h0, got_fail}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule